// File: doc/BRIEF.md
# Cache Miss Refill and Posted-Write Bus Controller

This controller sits between a CPU load/store port, an on-chip cache and a simple request/acknowledge memory bus. A load that hits the cache, with no cache parity error, is answered in the cycle it is presented. A load that misses claims a two-longword block. The controller fetches the requested longword first, hands it to the cache and the CPU in the same cycle, and releases the CPU. It then fetches the other longword of the block while the CPU runs on. The block is declared valid only when both halves arrive with good byte parity.

Stores go into a one-longword posted buffer, so the CPU moves on at once. Cache hits are served while the buffered store drains. A miss that arrives while a store is still buffered waits until that store has finished on the bus. An external master can take the bus through a request/grant handshake. While it holds the grant, it can present snoop addresses, and each one becomes a one-cycle invalidate command to the cache. A buffered store, a block refill and a snoop invalidate can all be in progress at the same time.

Top module: `miss_refill_ctrl`

## Requirements
- R1: A load with `cache_hit`=1 and `cache_perr`=0 raises `cpu_rvalid` in the same cycle with `cpu_rdata`=`cache_rdata`, `cpu_stall`=0, and starts no bus cycle. A hit that reports a cache parity error is handled as a miss.
- R2: On a load miss, `cpu_stall` is 1 from the request cycle until the cycle the first longword is acknowledged. With an idle bus, the first read request appears 2 cycles after the miss cycle, so `cpu_rvalid` rises L+2 cycles after the miss for a memory that acknowledges after L wait cycles.
- R3: The first bus read uses the requested longword address, with byte offset bits [1:0] cleared. Its data goes to `cpu_rdata` and to the cache fill port in the same cycle.
- R4: The second bus read is issued right after the first one and uses the requested address with bit 2 inverted. Its data is written through the fill port after the CPU has already been released.
- R5: `cache_validate` pulses in the cycle the second longword is acknowledged, with `cache_val_addr` = request address with bits [2:0] cleared. It pulses only if both longwords passed the parity check.
- R6: A store is accepted without stall in its request cycle when the buffer is empty. A store presented while the buffer is full is stalled. Loads that hit proceed while the buffer is full.
- R7: A load miss made while a store is buffered is not sent to the bus until that store's bus write has been acknowledged.
- R8: Parity is even per byte: bit i of a parity field equals the XOR of data bits [8i+7:8i]. A mismatch on `mem_rpar` pulses `cpu_err` in the acknowledge cycle. `mem_wpar` always follows the same rule for `mem_wdata`.
- R9: `snoop_strobe` is acted on only while `dma_gnt` is 1. It produces a one-cycle `cache_inv` pulse in the following cycle, with `cache_inv_addr` = the presented address. Without the grant, the strobe has no effect.
- R10: `dma_gnt` rises 2 cycles after the acknowledge that ends the bus cycle in progress (1 cycle after the bus goes idle) and is never 1 together with `mem_req`. While it is held, no bus cycle starts. It falls 1 cycle after `dma_req` falls.
- R11: After reset, `mem_req`, `dma_gnt`, `cache_inv`, `cache_validate` and `cpu_stall` are 0 and the store buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd_req | input | 1 | Load request, held until `cpu_rvalid` |
| cpu_wr_req | input | 1 | Store request |
| cpu_addr | input | AW | Byte address of the access |
| cpu_wdata | input | DW | Store data |
| cpu_stall | output | 1 | CPU must hold its request |
| cpu_rvalid | output | 1 | Load data valid this cycle |
| cpu_rdata | output | DW | Load data |
| cpu_err | output | 1 | Bus read parity error pulse |
| cache_hit | input | 1 | Cache lookup hit for `cpu_addr` |
| cache_perr | input | 1 | Cache parity error on the lookup |
| cache_rdata | input | DW | Cache data for a hit |
| cache_fill_we | output | 1 | Write one longword into the cache |
| cache_fill_addr | output | AW | Fill longword address |
| cache_fill_data | output | DW | Fill data |
| cache_validate | output | 1 | Mark the refilled block valid |
| cache_val_addr | output | AW | Base address of that block |
| cache_inv | output | 1 | Snoop invalidate command |
| cache_inv_addr | output | AW | Snoop address |
| mem_req | output | 1 | Bus cycle request, held until `mem_ack` |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Bus write data |
| mem_wpar | output | DW/8 | Even byte parity of `mem_wdata` |
| mem_ack | input | 1 | Bus cycle done |
| mem_rdata | input | DW | Bus read data |
| mem_rpar | input | DW/8 | Byte parity of `mem_rdata` |
| dma_req | input | 1 | External master bus request |
| dma_gnt | output | 1 | Bus granted to external master |
| snoop_strobe | input | 1 | Snoop address valid |
| snoop_addr | input | AW | Address to invalidate |

## Verification
The bench builds the controller with AW=16 and DW=32, which gives four parity lanes and makes address bit 2 the partner-longword bit. At that size it sweeps the memory latency from 0 to 3 wait cycles, both positions of the requested longword in its block, and a parity fault on no word, the first word or the second word. This covers every refill order together with every validate/error outcome, and lets the exact release cycle be predicted for each latency. Directed sequences add a store followed by a queued miss, a full-buffer stall, and a grant taken during a busy bus cycle with a snoop and a store made under the grant.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  typedef enum logic [1:0] {
    EX_IDLE = 2'd0,
    EX_WR   = 2'd1,
    EX_RD0  = 2'd2,
    EX_RD1  = 2'd3
  } ext_op_e;
endpackage

// File: rtl/mrc_par_gen.sv
module mrc_par_gen #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   data,
  output logic [DW/8-1:0] par
);
  localparam int NB = DW / 8;

  function automatic logic [NB-1:0] lane_parity(input logic [DW-1:0] d);
    logic [NB-1:0] p;
    for (int i = 0; i < NB; i++) p[i] = ^d[i*8 +: 8];
    return p;
  endfunction

  assign par = lane_parity(data);
endmodule

// File: rtl/mrc_wbuf.sv
module mrc_wbuf #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          drain,
  output logic          full,
  output logic          accept,
  output logic [AW-1:0] buf_addr,
  output logic [DW-1:0] buf_data
);
  logic          full_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign accept = wr_req & ~full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      addr_q <= wr_addr;
      data_q <= wr_data;
    end else if (drain) begin
      full_q <= 1'b0;
    end
  end

  assign full     = full_q;
  assign buf_addr = addr_q;
  assign buf_data = data_q;

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !drain) |=> (full_q && $stable(addr_q))); // R6
endmodule

// File: rtl/mrc_refill.sv
module mrc_refill #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_rd_req,
  input  logic [AW-1:0]  cpu_addr,
  input  logic           hit_ok,
  input  logic           rd_launch,
  input  logic           rd0_done,
  input  logic           rd1_done,
  input  logic           rd_active,
  input  logic [DW-1:0]  mem_rdata,
  input  logic [DW/8-1:0] mem_rpar,
  output logic           rd_pend,
  output logic [AW-1:0]  rd_addr,
  output logic [AW-1:0]  rd_alt_addr,
  output logic           fill_we,
  output logic [AW-1:0]  fill_addr,
  output logic [DW-1:0]  fill_data,
  output logic           validate,
  output logic [AW-1:0]  val_addr,
  output logic           par_fault
);
  localparam int NB  = DW / 8;
  localparam int SIB = $clog2(NB);

  function automatic logic [AW-1:0] lw_align(input logic [AW-1:0] a);
    return a & ~((AW'(1) << SIB) - AW'(1));
  endfunction

  function automatic logic [AW-1:0] partner_lw(input logic [AW-1:0] a);
    return a ^ (AW'(1) << SIB);
  endfunction

  function automatic logic [AW-1:0] blk_base(input logic [AW-1:0] a);
    return a & ~((AW'(1) << (SIB + 1)) - AW'(1));
  endfunction

  logic          pend_q;
  logic [AW-1:0] addr_q;
  logic          blk_err_q;
  logic          capture;
  logic          rd_busy;
  logic          rd_ack;
  logic [NB-1:0] calc_par;

  mrc_par_gen #(.DW(DW)) u_rpar (.data(mem_rdata), .par(calc_par));

  assign rd_busy   = pend_q | rd_active;
  assign capture   = cpu_rd_req & ~hit_ok & ~rd_busy;
  assign rd_ack    = rd0_done | rd1_done;
  assign par_fault = rd_ack & (calc_par != mem_rpar);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      addr_q    <= '0;
      blk_err_q <= 1'b0;
    end else begin
      if (capture) begin
        pend_q <= 1'b1;
        addr_q <= lw_align(cpu_addr);
      end else if (rd_launch) begin
        pend_q <= 1'b0;
      end
      if (rd_launch) blk_err_q <= 1'b0;
      else if (rd0_done && par_fault) blk_err_q <= 1'b1;
    end
  end

  assign rd_pend     = pend_q;
  assign rd_addr     = addr_q;
  assign rd_alt_addr = partner_lw(addr_q);
  assign fill_we     = rd_ack;
  assign fill_addr   = rd0_done ? addr_q : partner_lw(addr_q);
  assign fill_data   = mem_rdata;
  assign validate    = rd1_done & ~blk_err_q & ~par_fault;
  assign val_addr    = blk_base(addr_q);

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rd_launch) |=> (pend_q && $stable(addr_q))); // R7
  AST_FILL_IN_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> rd_active); // R3
endmodule

// File: rtl/mrc_ext_seq.sv
module mrc_ext_seq
  import mrc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_full,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  input  logic          rd_pend,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] rd_alt_addr,
  input  logic          mem_ack,
  input  logic          dma_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          dma_gnt,
  output logic          wr_done,
  output logic          rd0_done,
  output logic          rd1_done,
  output logic          rd_active,
  output logic          rd_launch
);
  ext_op_e op_q, op_d;
  logic    gnt_q;
  logic    bus_idle;
  logic    may_launch;
  logic    wr_launch;

  assign bus_idle   = (op_q == EX_IDLE);
  assign may_launch = bus_idle & ~dma_req & ~gnt_q;
  assign wr_launch  = may_launch & wb_full;
  assign rd_launch  = may_launch & ~wb_full & rd_pend;

  always_comb begin
    op_d = op_q;
    case (op_q)
      EX_IDLE: begin
        if (wr_launch)      op_d = EX_WR;
        else if (rd_launch) op_d = EX_RD0;
      end
      EX_WR:   if (mem_ack) op_d = EX_IDLE;
      EX_RD0:  if (mem_ack) op_d = EX_RD1;
      EX_RD1:  if (mem_ack) op_d = EX_IDLE;
      default: op_d = EX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= EX_IDLE;
      gnt_q <= 1'b0;
    end else begin
      op_q <= op_d;
      if (!dma_req)      gnt_q <= 1'b0;
      else if (bus_idle) gnt_q <= 1'b1;
    end
  end

  always_comb begin
    case (op_q)
      EX_WR:   mem_addr = wb_addr;
      EX_RD0:  mem_addr = rd_addr;
      EX_RD1:  mem_addr = rd_alt_addr;
      default: mem_addr = '0;
    endcase
  end

  assign mem_req   = ~bus_idle;
  assign mem_we    = (op_q == EX_WR);
  assign mem_wdata = wb_data;
  assign dma_gnt   = gnt_q;
  assign wr_done   = (op_q == EX_WR)  & mem_ack;
  assign rd0_done  = (op_q == EX_RD0) & mem_ack;
  assign rd1_done  = (op_q == EX_RD1) & mem_ack;
  assign rd_active = (op_q == EX_RD0) | (op_q == EX_RD1);

  AST_GNT_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_q |-> bus_idle); // R10
  AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_done |=> (op_q == EX_RD1)); // R4
endmodule

// File: rtl/mrc_snoop.sv
module mrc_snoop #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_gnt,
  input  logic          snoop_strobe,
  input  logic [AW-1:0] snoop_addr,
  output logic          inv,
  output logic [AW-1:0] inv_addr
);
  logic          inv_q;
  logic [AW-1:0] addr_q;
  logic          take;

  assign take = snoop_strobe & dma_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      inv_q <= take;
      if (take) addr_q <= snoop_addr;
    end
  end

  assign inv      = inv_q;
  assign inv_addr = addr_q;

  AST_INV_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    inv_q |-> $past(dma_gnt)); // R9
endmodule

// File: rtl/miss_refill_ctrl.sv
module miss_refill_ctrl #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_rd_req,
  input  logic            cpu_wr_req,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic            cpu_stall,
  output logic            cpu_rvalid,
  output logic [DW-1:0]   cpu_rdata,
  output logic            cpu_err,
  input  logic            cache_hit,
  input  logic            cache_perr,
  input  logic [DW-1:0]   cache_rdata,
  output logic            cache_fill_we,
  output logic [AW-1:0]   cache_fill_addr,
  output logic [DW-1:0]   cache_fill_data,
  output logic            cache_validate,
  output logic [AW-1:0]   cache_val_addr,
  output logic            cache_inv,
  output logic [AW-1:0]   cache_inv_addr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_wpar,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  input  logic [DW/8-1:0] mem_rpar,
  input  logic            dma_req,
  output logic            dma_gnt,
  input  logic            snoop_strobe,
  input  logic [AW-1:0]   snoop_addr
);
  logic          hit_ok;
  logic          wb_full, wb_accept;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic          rd_pend;
  logic [AW-1:0] rd_addr, rd_alt_addr;
  logic          wr_done, rd0_done, rd1_done, rd_active, rd_launch;
  logic          par_fault;

  assign hit_ok = cache_hit & ~cache_perr;

  mrc_wbuf #(.AW(AW), .DW(DW)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_req(cpu_wr_req), .wr_addr(cpu_addr), .wr_data(cpu_wdata),
    .drain(wr_done), .full(wb_full), .accept(wb_accept),
    .buf_addr(wb_addr), .buf_data(wb_data)
  );

  mrc_refill #(.AW(AW), .DW(DW)) u_refill (
    .clk(clk), .rst_n(rst_n),
    .cpu_rd_req(cpu_rd_req), .cpu_addr(cpu_addr), .hit_ok(hit_ok),
    .rd_launch(rd_launch), .rd0_done(rd0_done), .rd1_done(rd1_done),
    .rd_active(rd_active), .mem_rdata(mem_rdata), .mem_rpar(mem_rpar),
    .rd_pend(rd_pend), .rd_addr(rd_addr), .rd_alt_addr(rd_alt_addr),
    .fill_we(cache_fill_we), .fill_addr(cache_fill_addr),
    .fill_data(cache_fill_data), .validate(cache_validate),
    .val_addr(cache_val_addr), .par_fault(par_fault)
  );

  mrc_ext_seq #(.AW(AW), .DW(DW)) u_ext (
    .clk(clk), .rst_n(rst_n),
    .wb_full(wb_full), .wb_addr(wb_addr), .wb_data(wb_data),
    .rd_pend(rd_pend), .rd_addr(rd_addr), .rd_alt_addr(rd_alt_addr),
    .mem_ack(mem_ack), .dma_req(dma_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .dma_gnt(dma_gnt),
    .wr_done(wr_done), .rd0_done(rd0_done), .rd1_done(rd1_done),
    .rd_active(rd_active), .rd_launch(rd_launch)
  );

  mrc_snoop #(.AW(AW)) u_snoop (
    .clk(clk), .rst_n(rst_n), .dma_gnt(dma_gnt),
    .snoop_strobe(snoop_strobe), .snoop_addr(snoop_addr),
    .inv(cache_inv), .inv_addr(cache_inv_addr)
  );

  mrc_par_gen #(.DW(DW)) u_wpar (.data(mem_wdata), .par(mem_wpar));

  assign cpu_rvalid = cpu_rd_req & (hit_ok | rd0_done);
  assign cpu_rdata  = hit_ok ? cache_rdata : mem_rdata;
  assign cpu_err    = par_fault;
  assign cpu_stall  = (cpu_rd_req & ~cpu_rvalid) | (cpu_wr_req & ~wb_accept);

  AST_WR_BEFORE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_launch |-> !wb_full); // R7
  AST_ERR_NO_VALIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> !cache_validate); // R5
endmodule

// File: tb/miss_refill_ctrl_tb_top.sv
module miss_refill_ctrl_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_rd_req, cpu_wr_req;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic cpu_stall, cpu_rvalid, cpu_err;
  logic [DW-1:0] cpu_rdata;
  logic cache_hit, cache_perr;
  logic [DW-1:0] cache_rdata;
  logic cache_fill_we, cache_validate, cache_inv;
  logic [AW-1:0] cache_fill_addr, cache_val_addr, cache_inv_addr;
  logic [DW-1:0] cache_fill_data;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [NB-1:0] mem_wpar, mem_rpar;
  logic dma_req, dma_gnt, snoop_strobe;
  logic [AW-1:0] snoop_addr;

  int n_chk = 0;
  int n_bad = 0;
  int mem_lat = 0;
  int err_sel = 0;
  int rd_idx = 0;
  int wcnt = 0;
  int n_txn = 0;
  logic          t_we  [64];
  logic [AW-1:0] t_addr[64];
  logic [DW-1:0] t_data[64];
  logic          t_pok [64];

  always #2.5ns clk = ~clk;

  miss_refill_ctrl #(.AW(AW), .DW(DW)) dut_i (.*);

  function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, a + 16'h0101};
  endfunction

  function automatic logic [NB-1:0] bpar(input logic [DW-1:0] d);
    logic [NB-1:0] p;
    for (int i = 0; i < NB; i++) begin
      logic x;
      x = 1'b0;
      for (int b = 0; b < 8; b++) x = x ^ d[i*8 + b];
      p[i] = x;
    end
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: acknowledges after mem_lat wait cycles, one-cycle ack
  initial begin
    mem_ack = 1'b0; mem_rdata = '0; mem_rpar = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wcnt = 0;
      end else if (mem_req && rst_n) begin
        if (wcnt >= mem_lat) begin
          mem_ack = 1'b1;
          if (n_txn < 64) begin
            t_we[n_txn] = mem_we; t_addr[n_txn] = mem_addr;
            t_data[n_txn] = mem_wdata; t_pok[n_txn] = (mem_wpar == bpar(mem_wdata));
          end
          n_txn++;
          if (!mem_we) begin
            mem_rdata = memval(mem_addr);
            mem_rpar  = bpar(memval(mem_addr)) ^ ((err_sel == rd_idx + 1) ? NB'(1) : NB'(0));
            rd_idx++;
          end
        end else begin
          wcnt++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic do_miss(input logic [AW-1:0] addr, input int lat, input int e, input bit fake);
    int cyc, gotcyc, nf;
    bit got, valseen, errseen;
    logic [AW-1:0] fa[2];
    logic [DW-1:0] fd[2];
    logic [AW-1:0] va;
    cyc = 0; gotcyc = -1; nf = 0; got = 0; valseen = 0; errseen = 0; va = '0;
    mem_lat = lat; err_sel = e; rd_idx = 0;
    @(negedge clk);
    cpu_rd_req = 1'b1; cpu_addr = addr; cache_hit = fake; cache_perr = fake;
    while (nf < 2 && cyc < 60) begin
      #1ns;
      if (cpu_rd_req) begin
        if (cpu_rvalid) begin
          chk(cpu_stall == 1'b0, "R2 released", 32'(cpu_stall), 0);
          chk(cpu_rdata == memval(addr), "R3 cpu data", cpu_rdata, memval(addr));
          got = 1; gotcyc = cyc;
        end else begin
          chk(cpu_stall == 1'b1, "R2 stall", 32'(cpu_stall), 1);
        end
      end
      if (cache_fill_we && nf < 2) begin
        fa[nf] = cache_fill_addr; fd[nf] = cache_fill_data; nf++;
      end
      if (cache_validate) begin valseen = 1; va = cache_val_addr; end
      if (cpu_err) errseen = 1;
      @(negedge clk);
      if (got) begin cpu_rd_req = 1'b0; cache_hit = 1'b0; cache_perr = 1'b0; end
      cyc++;
    end
    chk(gotcyc == lat + 2, "R2 release cycle", 32'(gotcyc), 32'(lat + 2));
    if (fake) chk(got == 1'b1, "R1 perr hit refilled", 32'(got), 1);
    chk(fa[0] == addr, "R3 first addr", 32'(fa[0]), 32'(addr));
    chk(fd[0] == memval(addr), "R3 first fill", fd[0], memval(addr));
    chk(fa[1] == (addr ^ 16'h0004), "R4 second addr", 32'(fa[1]), 32'(addr ^ 16'h0004));
    chk(fd[1] == memval(addr ^ 16'h0004), "R4 second fill", fd[1], memval(addr ^ 16'h0004));
    chk(valseen == (e == 0), "R5 validate", 32'(valseen), 32'(e == 0));
    if (valseen) chk(va == (addr & 16'hFFF8), "R5 block addr", 32'(va), 32'(addr & 16'hFFF8));
    chk(errseen == (e != 0), "R8 parity error", 32'(errseen), 32'(e != 0));
    err_sel = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int ack_c, gnt_c, rv_txn, seen_req;
    rst_n = 1'b0; cpu_rd_req = 0; cpu_wr_req = 0; cpu_addr = '0; cpu_wdata = '0;
    cache_hit = 0; cache_perr = 0; cache_rdata = '0; dma_req = 0;
    snoop_strobe = 0; snoop_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1ns;
    // R11 reset state
    chk({mem_req, dma_gnt, cache_inv, cache_validate, cpu_stall} == 5'b0, "R11 reset outputs",
        32'({mem_req, dma_gnt, cache_inv, cache_validate, cpu_stall}), 0);
    @(negedge clk); cpu_wr_req = 1'b1; cpu_addr = 16'h0040; cpu_wdata = 32'h1;
    #1ns chk(cpu_stall == 1'b0, "R11 buffer empty", 32'(cpu_stall), 0);
    @(negedge clk); cpu_wr_req = 1'b0;
    repeat (8) @(negedge clk);

    // R1 hit: same-cycle data, no bus cycle
    cpu_rd_req = 1; cpu_addr = 16'h0200; cache_hit = 1; cache_rdata = 32'hCAFE_0123;
    #1ns;
    chk(cpu_rvalid == 1'b1, "R1 hit valid", 32'(cpu_rvalid), 1);
    chk(cpu_rdata == 32'hCAFE_0123, "R1 hit data", cpu_rdata, 32'hCAFE_0123);
    chk(cpu_stall == 1'b0, "R1 hit stall", 32'(cpu_stall), 0);
    @(negedge clk); cpu_rd_req = 0; cache_hit = 0;
    for (int i = 0; i < 3; i++) begin
      #1ns chk(mem_req == 1'b0, "R1 no bus cycle", 32'(mem_req), 0);
      @(negedge clk);
    end

    // refill sweep: latency x critical word x parity fault position
    for (int lat = 0; lat < 4; lat++)
      for (int off = 0; off < 2; off++)
        for (int e = 0; e < 3; e++)
          do_miss(AW'(16'h0100 + lat * 16'h40 + e * 16'h10 + off * 4), lat, e, 1'b0);
    do_miss(16'h0A04, 1, 0, 1'b1);  // R1 hit with cache parity error

    // R6/R7/R8 store buffer and queued miss
    n_txn = 0; mem_lat = 3;
    @(negedge clk); cpu_wr_req = 1; cpu_addr = 16'h0300; cpu_wdata = 32'h8181_7E00;
    #1ns chk(cpu_stall == 1'b0, "R6 store accepted", 32'(cpu_stall), 0);
    @(negedge clk); cpu_wr_req = 0; cpu_rd_req = 1; cpu_addr = 16'h0310; cache_hit = 1; cache_rdata = 32'h77;
    #1ns chk(cpu_rvalid == 1'b1 && cpu_rdata == 32'h77, "R6 hit during store", cpu_rdata, 32'h77);
    @(negedge clk); cpu_rd_req = 0; cache_hit = 0; cpu_wr_req = 1; cpu_addr = 16'h0304; cpu_wdata = 32'h5;
    #1ns chk(cpu_stall == 1'b1, "R6 full stall", 32'(cpu_stall), 1);
    @(negedge clk); cpu_wr_req = 0; cpu_rd_req = 1; cpu_addr = 16'h0408;
    rv_txn = -1;
    for (int c = 0; c < 40 && rv_txn < 0; c++) begin
      #1ns;
      if (cpu_rvalid) rv_txn = n_txn;
      @(negedge clk);
    end
    cpu_rd_req = 0;
    for (int c = 0; c < 40 && n_txn < 3; c++) @(negedge clk);
    chk(rv_txn == 2, "R7 write before read", 32'(rv_txn), 2);
    chk(t_we[0] == 1'b1 && t_addr[0] == 16'h0300, "R7 first txn is store", 32'(t_addr[0]), 32'h0300);
    chk(t_data[0] == 32'h8181_7E00, "R6 store data", t_data[0], 32'h8181_7E00);
    chk(t_pok[0] == 1'b1, "R8 write parity", 32'(t_pok[0]), 1);
    chk(t_we[1] == 1'b0 && t_addr[1] == 16'h0408, "R7 read after store", 32'(t_addr[1]), 32'h0408);
    repeat (3) @(negedge clk);

    // R9 strobe ignored without grant
    snoop_strobe = 1; snoop_addr = 16'h1234;
    @(negedge clk); snoop_strobe = 0;
    #1ns chk(cache_inv == 1'b0, "R9 ignored without grant", 32'(cache_inv), 0);

    // R10 grant waits for bus cycle in progress
    n_txn = 0; mem_lat = 2;
    @(negedge clk); cpu_wr_req = 1; cpu_addr = 16'h0500; cpu_wdata = 32'hA;
    @(negedge clk); cpu_wr_req = 0;
    @(negedge clk); dma_req = 1;
    ack_c = -1; gnt_c = -1;
    for (int c = 0; c < 10; c++) begin
      #1ns;
      if (mem_ack && ack_c < 0) ack_c = c;
      if (dma_gnt && gnt_c < 0) gnt_c = c;
      chk(!(dma_gnt && mem_req), "R10 exclusive", 32'({dma_gnt, mem_req}), 0);
      @(negedge clk);
    end
    chk(ack_c == 2 && gnt_c == ack_c + 2, "R10 grant timing", 32'(gnt_c), 32'(ack_c + 2));
    cpu_wr_req = 1; cpu_addr = 16'h0520; cpu_wdata = 32'hB;
    #1ns chk(cpu_stall == 1'b0, "R6 store under grant", 32'(cpu_stall), 0);
    @(negedge clk); cpu_wr_req = 0;
    for (int c = 0; c < 5; c++) begin
      #1ns chk(mem_req == 1'b0, "R10 no cycle while granted", 32'(mem_req), 0);
      @(negedge clk);
    end
    snoop_strobe = 1; snoop_addr = 16'h0ABC;
    #1ns chk(cache_inv == 1'b0, "R9 not same cycle", 32'(cache_inv), 0);
    @(negedge clk); snoop_strobe = 0;
    #1ns chk(cache_inv == 1'b1 && cache_inv_addr == 16'h0ABC, "R9 invalidate", 32'(cache_inv_addr), 32'h0ABC);
    @(negedge clk);
    #1ns chk(cache_inv == 1'b0, "R9 single pulse", 32'(cache_inv), 0);
    dma_req = 0;
    @(negedge clk);
    #1ns chk(dma_gnt == 1'b0, "R10 release", 32'(dma_gnt), 0);
    seen_req = 0;
    for (int c = 0; c < 20 && n_txn < 2; c++) begin
      #1ns if (mem_req && mem_we) seen_req = 1;
      @(negedge clk);
    end
    chk(seen_req == 1 && n_txn == 2 && t_addr[1] == 16'h0520, "R10 store after release", 32'(t_addr[1]), 32'h0520);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule